// File: doc/BRIEF.md
# Toroidal Eight-Neighbour Serial Mesh

This block is the nearest-neighbour fabric for a rectangular grid of processing elements. By default the grid has 32 elements in 4 rows of 8. Under one shared control, every element sends a word to the same compass neighbour, one bit per clock. Eight directions are available, and the grid wraps in both axes, so elements on the edge have a full set of neighbours. A larger grid made of several copies wraps in the same way.

Each element has only four physical links, one at each of its corners. A crossing node sits at every corner point, where four elements meet. For the selected direction, the node takes the stream from one corner and steers it onto one of two paths. It passes straight through for a diagonal move and turns for an orthogonal move. The node is a one-hot multiplexer, so no link ever has more than one driver.

A transfer starts with a one-cycle start strobe. At that moment the block samples the direction, the word length and every element's send word. The words then move least-significant bit first. When the last bit has arrived, done pulses and each active element's receive word is updated. Elements cleared in the active mask keep their old receive word, but they still carry traffic through the crossing nodes.

Top module: `torusNeighbourMesh`

## Requirements
- R1: After reset every receive word is zero and done is low.
- R2: Element index is row*COLS+col, with row 0 northernmost and column 0 westernmost. Word i sits at bits [i*WORD_W +: WORD_W] of the send and receive buses. The direction codes are 0=N, 1=NE, 2=E, 3=SE, 4=S, 5=SW, 6=W and 7=NW. N means row-1 and E means col+1. For a direction with offset (dr,dc), the element at (r,c) receives the word of the element at (r-dr, c-dc).
- R3: Row and column arithmetic wraps modulo ROWS and COLS, so edge elements take their words from the opposite edge.
- R4: Done is high for exactly one cycle. It rises L clock edges after the edge that accepts start, where L is the effective length.
- R5: Only the low L bits of the sender's word are delivered, and the received bits above L are zero. A word length of 0, or one larger than WORD_W, means L = WORD_W.
- R6: An element whose active-mask bit is 0 when done is produced keeps its previous receive word.
- R7: A start strobe that arrives during a transfer is ignored. Direction, length and send words are sampled only at the edge that accepts start.
- R8: Receive words change only on the edge that raises done.
- R9: At each crossing node, at most one corner feeds the node and at most one corner is driven from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer when idle |
| dirCode | input | 3 | Shared transfer direction |
| wordLen | input | LEN_W (6) | Bits per word; 0 or more than WORD_W means WORD_W |
| activeMask | input | ROWS*COLS | Per-element receive enable |
| sendFlat | input | ROWS*COLS*WORD_W | Send words of all elements |
| recvFlat | output | ROWS*COLS*WORD_W | Receive words of all elements |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can fall in the same cycle: a start strobe that arrives while the control is still shifting, and the serial bit capture that is running at that moment. The bench provokes this by raising start part-way through a full-length transfer. On that same cycle it also changes the direction and every send word. The case is judged at the ports: done must still rise on the cycle set by the first request, and every receive word must match the words and direction that were sampled at the first accept. Masked elements, short lengths and out-of-range lengths are checked in the same way, against a model that tracks each element's last received word.

// File: rtl/meshPkg.sv
package meshPkg;

  // Corner terminal of a crossing node, named by where the element sits
  // relative to the node.
  localparam logic [1:0] TERM_NW = 2'd0;
  localparam logic [1:0] TERM_NE = 2'd1;
  localparam logic [1:0] TERM_SW = 2'd2;
  localparam logic [1:0] TERM_SE = 2'd3;

  typedef struct packed {
    logic load;   // accept a new transfer this edge
    logic shift;  // move one bit across the fabric
    logic last;   // final bit of the word
  } meshStrobeT;

  // The corner a sender drives for a given direction
  function automatic logic [1:0] srcTerm(input logic [2:0] d);
    case (d)
      3'd0, 3'd1: srcTerm = TERM_SW;
      3'd2, 3'd3: srcTerm = TERM_NW;
      3'd4, 3'd5: srcTerm = TERM_NE;
      default:    srcTerm = TERM_SE;
    endcase
  endfunction

  // The corner the node steers the stream onto
  function automatic logic [1:0] dstTerm(input logic [2:0] d);
    case (d)
      3'd0, 3'd7: dstTerm = TERM_NW;
      3'd1, 3'd2: dstTerm = TERM_NE;
      3'd3, 3'd4: dstTerm = TERM_SE;
      default:    dstTerm = TERM_SW;
    endcase
  endfunction

endpackage

// File: rtl/meshXNode.sv
module meshXNode (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] termIn,
  input  logic [3:0] srcSel,
  input  logic [3:0] dstSel,
  output logic [3:0] termOut
);
  logic passBit;

  always_comb begin
    passBit = |(termIn & srcSel);
    termOut = dstSel & {4{passBit}};
  end

  // R9
  single_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(srcSel));

  // R9
  single_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(termOut));

endmodule

// File: rtl/meshCtrl.sv
module meshCtrl
  import meshPkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 6,
  parameter int IDX_W  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [2:0]       dirCode,
  input  logic [LEN_W-1:0] wordLen,
  output meshStrobeT       strb,
  output logic [IDX_W-1:0] bitIdx,
  output logic [2:0]       dirQ
);
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(WORD_W);

  logic             busy;
  logic [IDX_W-1:0] lastIdx;
  logic [LEN_W-1:0] effLen;

  always_comb begin
    if (wordLen == '0 || wordLen > FULL_LEN) effLen = FULL_LEN;
    else                                     effLen = wordLen;
    strb.load  = start && !busy;
    strb.shift = busy;
    strb.last  = busy && (bitIdx == lastIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      bitIdx  <= '0;
      lastIdx <= '0;
      dirQ    <= 3'd0;
    end else if (strb.load) begin
      busy    <= 1'b1;
      bitIdx  <= '0;
      lastIdx <= IDX_W'(effLen - LEN_W'(1));
      dirQ    <= dirCode;
    end else if (busy) begin
      bitIdx <= bitIdx + IDX_W'(1);
      if (strb.last) busy <= 1'b0;
    end
  end

  // R4
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitIdx <= lastIdx));

  // R4
  last_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.last |=> !busy);

  // R7
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(dirQ));

endmodule

// File: rtl/meshData.sv
module meshData
  import meshPkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 8,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  meshStrobeT                  strb,
  input  logic [IDX_W-1:0]            bitIdx,
  input  logic [2:0]                  dirQ,
  input  logic [ROWS*COLS-1:0]        activeMask,
  input  logic [ROWS*COLS*WORD_W-1:0] sendFlat,
  output logic [ROWS*COLS*WORD_W-1:0] recvFlat,
  output logic                        done
);
  localparam int NPE = ROWS * COLS;

  logic [1:0] srcIdx, dstIdx;
  logic [3:0] srcOh, dstOh;

  logic [3:0]        peOut   [NPE];
  logic [3:0]        peIn    [NPE];
  logic [3:0]        nodeIn  [NPE];
  logic [3:0]        nodeOut [NPE];
  logic [NPE-1:0]    rxBit;
  logic [WORD_W-1:0] sendSh   [NPE];
  logic [WORD_W-1:0] stage    [NPE];
  logic [WORD_W-1:0] stageNxt [NPE];

  always_comb begin
    srcIdx = srcTerm(dirQ);
    dstIdx = dstTerm(dirQ);
    srcOh  = 4'b0001 << srcIdx;
    dstOh  = 4'b0001 << dstIdx;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int I  = r * COLS + c;
      localparam int RP = (r + 1) % ROWS;
      localparam int RM = (r + ROWS - 1) % ROWS;
      localparam int CP = (c + 1) % COLS;
      localparam int CM = (c + COLS - 1) % COLS;

      // The element drives only the corner picked by the direction.
      assign peOut[I] = srcOh & {4{sendSh[I][0]}};

      // Node at this element's south-east corner
      assign nodeIn[I] = {peOut[RP*COLS+CP][3], peOut[RP*COLS+c][2],
                          peOut[r*COLS+CP][1], peOut[I][0]};

      meshXNode u_node (
        .clk    (clk),
        .rstN   (rstN),
        .termIn (nodeIn[I]),
        .srcSel (srcOh),
        .dstSel (dstOh),
        .termOut(nodeOut[I])
      );

      // The element's four corner links, one on each node it touches
      assign peIn[I]  = {nodeOut[RM*COLS+CM][3], nodeOut[RM*COLS+c][2],
                         nodeOut[r*COLS+CM][1], nodeOut[I][0]};
      assign rxBit[I] = peIn[I][dstIdx];

      always_comb begin
        stageNxt[I]         = stage[I];
        stageNxt[I][bitIdx] = rxBit[I];
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sendSh[I]                  <= '0;
          stage[I]                   <= '0;
          recvFlat[I*WORD_W +: WORD_W] <= '0;
        end else if (strb.load) begin
          sendSh[I] <= sendFlat[I*WORD_W +: WORD_W];
          stage[I]  <= '0;
        end else if (strb.shift) begin
          sendSh[I] <= sendSh[I] >> 1;
          stage[I]  <= stageNxt[I];
          if (strb.last && activeMask[I])
            recvFlat[I*WORD_W +: WORD_W] <= stageNxt[I];
        end
      end

      // R6
      masked_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        (strb.last && !activeMask[I]) |=> $stable(recvFlat[I*WORD_W +: WORD_W]));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else       done <= strb.last;
  end

  // R8
  recv_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.last |=> $stable(recvFlat));

endmodule

// File: rtl/torusNeighbourMesh.sv
module torusNeighbourMesh
  import meshPkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 8,
  parameter int WORD_W = 32,
  localparam int NPE   = ROWS * COLS,
  localparam int LEN_W = $clog2(WORD_W + 1),
  localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [2:0]            dirCode,
  input  logic [LEN_W-1:0]      wordLen,
  input  logic [NPE-1:0]        activeMask,
  input  logic [NPE*WORD_W-1:0] sendFlat,
  output logic [NPE*WORD_W-1:0] recvFlat,
  output logic                  done
);
  meshStrobeT       strb;
  logic [IDX_W-1:0] bitIdx;
  logic [2:0]       dirQ;

  meshCtrl #(.WORD_W(WORD_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .dirCode(dirCode),
    .wordLen(wordLen),
    .strb   (strb),
    .bitIdx (bitIdx),
    .dirQ   (dirQ)
  );

  meshData #(.ROWS(ROWS), .COLS(COLS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .bitIdx    (bitIdx),
    .dirQ      (dirQ),
    .activeMask(activeMask),
    .sendFlat  (sendFlat),
    .recvFlat  (recvFlat),
    .done      (done)
  );

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: tb/torusNeighbourMesh_tb.sv
module torusNeighbourMesh_tb;
  localparam int ROWS = 4;
  localparam int COLS = 8;
  localparam int W    = 32;
  localparam int NPE  = ROWS * COLS;
  localparam int NV   = 12;

  // direction, word length, active mask, seed
  localparam int          V_DIR [NV] = '{0, 1, 2, 3, 4, 5, 6, 7, 2, 7, 3, 5};
  localparam int          V_LEN [NV] = '{32, 32, 32, 32, 32, 32, 32, 32, 5, 1, 0, 40};
  localparam logic [31:0] V_MSK [NV] = '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
                                         32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
                                         32'hFFFFFFFF, 32'hFFFFFFFF, 32'hA5A5F00F,
                                         32'hFFFFFFFF, 32'hFFFF0000, 32'h00000000};

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [2:0]        dirCode = 3'd0;
  logic [5:0]        wordLen = 6'd0;
  logic [NPE-1:0]    activeMask = '0;
  logic [NPE*W-1:0]  sendFlat = '0;
  logic [NPE*W-1:0]  recvFlat;
  logic              done;

  int nChk = 0;
  int nFail = 0;
  int cycles = 0;
  logic [W-1:0] expRecv [NPE];

  always #2.5 clk = ~clk;

  torusNeighbourMesh u_dut (
    .clk(clk), .rstN(rstN), .start(start), .dirCode(dirCode),
    .wordLen(wordLen), .activeMask(activeMask), .sendFlat(sendFlat),
    .recvFlat(recvFlat), .done(done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFail++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int dRow(input int d);
    case (d)
      0, 1, 7: return -1;
      3, 4, 5: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int dCol(input int d);
    case (d)
      1, 2, 3: return 1;
      5, 6, 7: return -1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [W-1:0] mkWord(input int seed, input int i);
    logic [W-1:0] a;
    a = (32'h9E3779B9 * (seed + 1)) ^ ((i + 3) * 32'h01030507);
    return a ^ (32'h1 << ((i + seed) % 32)) ^ W'(i);
  endfunction

  // One transfer; poke raises a second start mid-transfer with other inputs.
  task automatic runXfer(input int d, input int len, input logic [31:0] msk,
                         input int seed, input bit poke);
    int eff;
    logic [W-1:0] lenMsk;
    logic [NPE*W-1:0] snap;
    eff = (len == 0 || len > W) ? W : len;
    lenMsk = (eff == W) ? '1 : ((W'(1) << eff) - W'(1));
    for (int i = 0; i < NPE; i++) sendFlat[i*W +: W] = mkWord(seed, i);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        int sr, sc;
        sr = (r - dRow(d) + ROWS) % ROWS;
        sc = (c - dCol(d) + COLS) % COLS;
        if (msk[r*COLS+c]) expRecv[r*COLS+c] = mkWord(seed, sr*COLS+sc) & lenMsk;
      end
    dirCode = 3'(d);
    wordLen = 6'(len);
    activeMask = msk;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    snap = recvFlat;
    for (int j = 1; j <= eff; j++) begin
      if (poke && j == 1) begin
        start = 1'b1;
        dirCode = 3'(d + 3);
        wordLen = 6'd2;
        for (int i = 0; i < NPE; i++) sendFlat[i*W +: W] = ~mkWord(seed, i);
      end
      if (poke && j == 2) start = 1'b0;
      @(negedge clk);
      if (j < eff) begin
        chk(done == 1'b0, poke ? "R7 early done" : "R4 early done", W'(done), 0);
        chk(recvFlat == snap, "R8 recv moved before done", recvFlat[W-1:0], snap[W-1:0]);
      end else begin
        chk(done == 1'b1, poke ? "R7 done timing" : "R4 done timing", W'(done), 1);
      end
    end
    for (int i = 0; i < NPE; i++) begin
      string tag;
      if (poke)             tag = "R7 sampled at accept";
      else if (!msk[i])     tag = "R6 masked element";
      else if (eff < W)     tag = "R5 length";
      else if ((i / COLS) == 0 || (i / COLS) == ROWS-1 || (i % COLS) == 0 || (i % COLS) == COLS-1)
                            tag = "R3 wrap";
      else                  tag = "R2 neighbour";
      chk(recvFlat[i*W +: W] == expRecv[i], tag, recvFlat[i*W +: W], expRecv[i]);
    end
    @(negedge clk);
    chk(done == 1'b0, "R4 pulse width", W'(done), 0);
  endtask

  initial begin
    for (int i = 0; i < NPE; i++) expRecv[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(done == 1'b0, "R1 done at reset", W'(done), 0);
    for (int i = 0; i < NPE; i++)
      chk(recvFlat[i*W +: W] == '0, "R1 recv at reset", recvFlat[i*W +: W], 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R1 idle after reset", W'(done), 0);

    for (int v = 0; v < NV; v++)
      runXfer(V_DIR[v], V_LEN[v], V_MSK[v], v + 1, 1'b0);

    // R7 start raised during a transfer is ignored
    runXfer(3, 32, 32'hFFFFFFFF, 40, 1'b1);
    // back-to-back after the ignored request
    runXfer(6, 3, 32'h0F0F0F0F, 41, 1'b0);
    // R5 length one on a diagonal with partial mask
    runXfer(1, 1, 32'h3C3C3C3C, 42, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule